// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control and status bank for a 64-channel DMA controller. Per-channel state is kept in four 64-bit bitmaps: request enable, error-interrupt enable, completion pending and error pending. Each bitmap is read and written as two 32-bit words, an upper word for channels 63..32 and a lower word for channels 31..0. Software can also reach a single channel through command ports. It writes a channel number to a command port to set or clear one enable bit, or to fire a one-cycle start or done-clear strobe towards that channel's engine.

The channel engines report completions as a per-channel done vector. They report errors one at a time as a channel number plus a cause mask. Completion and error events set pending bits, and software clears those bits by writing ones. The first error is frozen in a status word. A two-state machine owns that word. In `ES_IDLE` it waits. The transition *capture* moves it to `ES_HELD` when an error arrives. In `ES_HELD` it ignores later errors until software clears the erring channel's error-pending bit. That event takes the transition *release* back to `ES_IDLE`, or the transition *recapture* if another error lands in the same cycle, in which case the machine stays in `ES_HELD` with the new error. A control word carries three arbitration and clocking mode bits out to the engine.

Top module: `dma_chreg_bank`

## Requirements
- R1: After reset, every register reads zero, and the bitmaps, strobes, mode outputs and `irq` are all zero.
- R2: Register map (word index on `bus_addr`): 0 control, 1 error status, 2/3 request-enable upper/lower, 4/5 error-interrupt-enable upper/lower, 6 set request, 7 clear request, 8 set error-interrupt, 9 clear error-interrupt, 10 start, 11 done-clear, 12/13 completion-pending upper/lower, 14/15 error-pending upper/lower. Upper words map channel 32+i to bit i, and lower words map channel i to bit i. Whole-word writes to the enable words replace those 32 bits.
- R3: Writing channel n (bits 5:0) to index 6 sets request-enable bit n, and writing it to index 7 clears that bit. The other bits do not change.
- R4: Writing channel n to index 8 sets error-interrupt-enable bit n, and writing it to index 9 clears that bit.
- R5: Writing channel n to index 10 (or 11) raises only bit n of `start_pulse` (or `done_clr_pulse`) for exactly the one cycle after the write.
- R6: A write to indices 6..11 whose bits 7:6 are not both zero has no effect. Those indices always read as zero.
- R7: `ev_done[n]` sets completion-pending bit n, and an error event sets error-pending bit of `ev_err_ch`. In the pending words, a written 1 clears the bit and a written 0 leaves it unchanged.
- R8: If an event sets a pending bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R9: The error status word is 0 when idle. On the first error it becomes bit 31 = 1, bits 13:8 = channel, plus the cause bits kept by the mask 0xC0FF (bits 15,14,7..0). While it is held, later errors do not change it.
- R10: Clearing the held channel's error-pending bit returns the status to 0. The exception is an error in the same cycle. If that error is on the held channel, the status is kept. If it is on another channel, that error is captured instead.
- R11: The control word keeps only bits 31, 3 and 2, which drive `dyn_clk_en`, `rr_group` and `rr_chan`. All other bits read 0.
- R12: `irq` is high when any completion-pending bit is set, or when any error-pending bit is set and its error-interrupt-enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_done | input | 64 | Per-channel completion events |
| ev_err_vld | input | 1 | Error event valid |
| ev_err_ch | input | 6 | Channel of the error event |
| ev_err_cause | input | 16 | Cause mask of the error event |
| req_en | output | 64 | Request-enable bitmap |
| err_ie | output | 64 | Error-interrupt-enable bitmap |
| start_pulse | output | 64 | One-cycle start strobes |
| done_clr_pulse | output | 64 | One-cycle done-clear strobes |
| dyn_clk_en | output | 1 | Dynamic clock mode bit |
| rr_group | output | 1 | Round-robin group arbitration bit |
| rr_chan | output | 1 | Round-robin channel arbitration bit |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions watch several properties on every cycle. Strobes must stay one-hot, and malformed command writes must leave the enables and strobes untouched. A command must land on the addressed bit. An event must survive a simultaneous clear. The held error record must stay frozen until its release. Other behaviours can only be shown by the bench's scenarios against its reference model. These include the exact status word layout, the hi/lo word mapping, the choice of channel on recapture, and the combination of pending and enable bits behind `irq`.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
    localparam int NCH     = 64;
    localparam int CH_W    = 6;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CAUSE_W = 16;

    localparam logic [WORD_W-1:0]  CTRL_MASK  = 32'h8000_000C;
    localparam logic [CAUSE_W-1:0] CAUSE_MASK = 16'hC0FF;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 4'd0,  A_ESTAT   = 4'd1,
        A_REQ_HI  = 4'd2,  A_REQ_LO  = 4'd3,
        A_EIE_HI  = 4'd4,  A_EIE_LO  = 4'd5,
        A_C_SREQ  = 4'd6,  A_C_CREQ  = 4'd7,
        A_C_SEIE  = 4'd8,  A_C_CEIE  = 4'd9,
        A_C_START = 4'd10, A_C_DCLR  = 4'd11,
        A_IRQ_HI  = 4'd12, A_IRQ_LO  = 4'd13,
        A_ERR_HI  = 4'd14, A_ERR_LO  = 4'd15
    } reg_addr_e;

    typedef enum logic [0:0] {ES_IDLE = 1'b0, ES_HELD = 1'b1} es_state_e;

    typedef struct packed {
        logic [CH_W-1:0]    ch;
        logic [CAUSE_W-1:0] cause;
    } err_rec_t;
endpackage

// File: rtl/chan_bitmap.sv
module chan_bitmap #(
    parameter int NCH    = 64,
    parameter int CH_W   = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [WORD_W-1:0] wdata,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [CH_W-1:0]   idx,
    output logic [NCH-1:0]    q
);
    localparam int HI_W = NCH - WORD_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (wr_hi)  q[NCH-1:WORD_W]  <= wdata[HI_W-1:0];
            if (wr_lo)  q[WORD_W-1:0]    <= wdata;
            if (set_en) q[idx]           <= 1'b1;
            if (clr_en) q[idx]           <= 1'b0;
        end
    end

    // R3 / R4: a single-channel command lands on the addressed bit
    p_cmd_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> q[$past(idx)]);
    p_cmd_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !q[$past(idx)]);
endmodule

// File: rtl/pend_bitmap.sv
module pend_bitmap #(
    parameter int NCH    = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w1c_hi,
    input  logic              w1c_lo,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NCH-1:0]    ev,
    output logic [NCH-1:0]    clr_mask,
    output logic [NCH-1:0]    q
);
    localparam int HI_W = NCH - WORD_W;

    always_comb begin
        clr_mask = '0;
        if (w1c_hi) clr_mask[NCH-1:WORD_W] = wdata[HI_W-1:0];
        if (w1c_lo) clr_mask[WORD_W-1:0]   = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_mask) | ev;
    end

    // R8: an event survives a same-cycle clear
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((q & $past(ev)) == $past(ev)));
    // R7: ones written to the low word clear those bits when no event collides
    p_w1c_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_lo && ev == '0) |=> ((q[WORD_W-1:0] & $past(wdata)) == '0));
endmodule

// File: rtl/err_capture.sv
module err_capture
    import dmacr_pkg::*;
#(
    parameter int NCH    = 64,
    parameter int CH_W   = 6,
    parameter int WORD_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_vld,
    input  logic [CH_W-1:0]    ev_ch,
    input  logic [CAUSE_W-1:0] ev_cause,
    input  logic [NCH-1:0]     clr_mask,
    output logic [WORD_W-1:0]  status
);
    localparam int VLD_BIT = WORD_W - 1;
    localparam int CH_LSB  = 8;

    es_state_e state_q, state_d;
    err_rec_t  rec_q;
    logic      release_hit;
    logic      load;

    assign release_hit = (state_q == ES_HELD) && clr_mask[rec_q.ch]
                         && !(ev_vld && ev_ch == rec_q.ch);
    assign load = ev_vld && ((state_q == ES_IDLE) || release_hit);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ES_IDLE: if (ev_vld)      state_d = ES_HELD;                      // capture
            ES_HELD: if (release_hit) state_d = ev_vld ? ES_HELD : ES_IDLE;   // recapture / release
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ES_IDLE;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)             rec_q <= '{ch: ev_ch, cause: ev_cause & CAUSE_MASK};
            else if (release_hit) rec_q <= '0;
        end
    end

    always_comb begin
        status = '0;
        if (state_q == ES_HELD) begin
            status[CAUSE_W-1:0]             = rec_q.cause;
            status[CH_LSB +: CH_W]          = rec_q.ch;
            status[VLD_BIT]                 = 1'b1;
        end
    end

    // R9: first error captured, then frozen
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ES_IDLE && ev_vld) |=> (status[VLD_BIT] && status[CH_LSB +: CH_W] == $past(ev_ch)));
    p_hold_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ES_HELD && !clr_mask[rec_q.ch]) |=> ($stable(status) && status[VLD_BIT]));
    // R10: clearing the held channel without a new error frees the word
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ES_HELD && clr_mask[rec_q.ch] && !ev_vld) |=> (status == '0));
endmodule

// File: rtl/dma_chreg_bank.sv
module dma_chreg_bank
    import dmacr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NCH-1:0]      ev_done,
    input  logic                ev_err_vld,
    input  logic [CH_W-1:0]     ev_err_ch,
    input  logic [CAUSE_W-1:0]  ev_err_cause,
    output logic [NCH-1:0]      req_en,
    output logic [NCH-1:0]      err_ie,
    output logic [NCH-1:0]      start_pulse,
    output logic [NCH-1:0]      done_clr_pulse,
    output logic                dyn_clk_en,
    output logic                rr_group,
    output logic                rr_chan,
    output logic                irq
);
    localparam int CMD_W = 8;
    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    logic [CH_W-1:0]   cmd_idx;
    logic              cmd_ok;
    logic [NCH-1:0]    cmd_onehot;
    logic [NCH-1:0]    err_ev_vec;
    logic [NCH-1:0]    irq_pend, err_pend, irq_clr, err_clr;
    logic [WORD_W-1:0] ctrl_q, estat;

    function automatic logic wr_at(input reg_addr_e a);
        return bus_wr && (bus_addr == a);
    endfunction

    assign cmd_idx    = bus_wdata[CH_W-1:0];
    assign cmd_ok     = (bus_wdata[CMD_W-1:CH_W] == '0);
    assign cmd_onehot = ONE << cmd_idx;
    assign err_ev_vec = ev_err_vld ? (ONE << ev_err_ch) : '0;

    chan_bitmap #(.NCH(NCH), .CH_W(CH_W), .WORD_W(WORD_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_at(A_REQ_HI)), .wr_lo(wr_at(A_REQ_LO)), .wdata(bus_wdata),
        .set_en(wr_at(A_C_SREQ) && cmd_ok), .clr_en(wr_at(A_C_CREQ) && cmd_ok),
        .idx(cmd_idx), .q(req_en));

    chan_bitmap #(.NCH(NCH), .CH_W(CH_W), .WORD_W(WORD_W)) u_eie (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_at(A_EIE_HI)), .wr_lo(wr_at(A_EIE_LO)), .wdata(bus_wdata),
        .set_en(wr_at(A_C_SEIE) && cmd_ok), .clr_en(wr_at(A_C_CEIE) && cmd_ok),
        .idx(cmd_idx), .q(err_ie));

    pend_bitmap #(.NCH(NCH), .WORD_W(WORD_W)) u_irqp (
        .clk(clk), .rst_n(rst_n),
        .w1c_hi(wr_at(A_IRQ_HI)), .w1c_lo(wr_at(A_IRQ_LO)), .wdata(bus_wdata),
        .ev(ev_done), .clr_mask(irq_clr), .q(irq_pend));

    pend_bitmap #(.NCH(NCH), .WORD_W(WORD_W)) u_errp (
        .clk(clk), .rst_n(rst_n),
        .w1c_hi(wr_at(A_ERR_HI)), .w1c_lo(wr_at(A_ERR_LO)), .wdata(bus_wdata),
        .ev(err_ev_vec), .clr_mask(err_clr), .q(err_pend));

    err_capture #(.NCH(NCH), .CH_W(CH_W), .WORD_W(WORD_W)) u_es (
        .clk(clk), .rst_n(rst_n),
        .ev_vld(ev_err_vld), .ev_ch(ev_err_ch), .ev_cause(ev_err_cause),
        .clr_mask(err_clr), .status(estat));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q         <= '0;
            start_pulse    <= '0;
            done_clr_pulse <= '0;
        end else begin
            if (wr_at(A_CTRL)) ctrl_q <= bus_wdata & CTRL_MASK;
            start_pulse    <= (wr_at(A_C_START) && cmd_ok) ? cmd_onehot : '0;
            done_clr_pulse <= (wr_at(A_C_DCLR)  && cmd_ok) ? cmd_onehot : '0;
        end
    end

    assign dyn_clk_en = ctrl_q[31];
    assign rr_group   = ctrl_q[3];
    assign rr_chan    = ctrl_q[2];
    assign irq        = (|irq_pend) | (|(err_pend & err_ie));

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            A_CTRL:   bus_rdata = ctrl_q;
            A_ESTAT:  bus_rdata = estat;
            A_REQ_HI: bus_rdata = req_en[NCH-1:WORD_W];
            A_REQ_LO: bus_rdata = req_en[WORD_W-1:0];
            A_EIE_HI: bus_rdata = err_ie[NCH-1:WORD_W];
            A_EIE_LO: bus_rdata = err_ie[WORD_W-1:0];
            A_IRQ_HI: bus_rdata = irq_pend[NCH-1:WORD_W];
            A_IRQ_LO: bus_rdata = irq_pend[WORD_W-1:0];
            A_ERR_HI: bus_rdata = err_pend[NCH-1:WORD_W];
            A_ERR_LO: bus_rdata = err_pend[WORD_W-1:0];
            default:  bus_rdata = '0;
        endcase
    end

    // R5: strobes are at most one channel wide
    p_start_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse) && $onehot0(done_clr_pulse));
    // R6: malformed command writes change nothing
    p_bad_cmd_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= A_C_SREQ && bus_addr <= A_C_DCLR && !cmd_ok)
        |=> ($stable(req_en) && $stable(err_ie) && start_pulse == '0 && done_clr_pulse == '0));
endmodule

// File: tb/dma_chreg_bank_test.sv
module dma_chreg_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] ev_done = '0;
    logic        ev_err_vld = 1'b0;
    logic [5:0]  ev_err_ch = '0;
    logic [15:0] ev_err_cause = '0;
    logic [63:0] req_en, err_ie, start_pulse, done_clr_pulse;
    logic        dyn_clk_en, rr_group, rr_chan, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // reference model state
    logic [63:0] m_req = '0, m_eie = '0, m_irq = '0, m_err = '0, m_st = '0, m_dc = '0;
    logic [31:0] m_ctrl = '0;
    bit          m_es_vld = 0;
    logic [5:0]  m_es_ch = '0;
    logic [15:0] m_es_cause = '0;
    bit          model_live = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chreg_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
        .ev_err_vld(ev_err_vld), .ev_err_ch(ev_err_ch), .ev_err_cause(ev_err_cause),
        .req_en(req_en), .err_ie(err_ie), .start_pulse(start_pulse),
        .done_clr_pulse(done_clr_pulse), .dyn_clk_en(dyn_clk_en),
        .rr_group(rr_group), .rr_chan(rr_chan), .irq(irq));

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] m_estat();
        return m_es_vld ? (32'h8000_0000 | (32'(m_es_ch) << 8) | 32'(m_es_cause)) : 32'h0;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return m_ctrl;
            4'd1:  return m_estat();
            4'd2:  return m_req[63:32];
            4'd3:  return m_req[31:0];
            4'd4:  return m_eie[63:32];
            4'd5:  return m_eie[31:0];
            4'd12: return m_irq[63:32];
            4'd13: return m_irq[31:0];
            4'd14: return m_err[63:32];
            4'd15: return m_err[31:0];
            default: return 32'h0;
        endcase
    endfunction

    // behavioural model step, using inputs held steady across the edge
    task automatic model_step();
        logic [63:0] bit_n, clr_i, clr_e, eev;
        bit ok, rel;
        if (!rst_n) begin
            m_req = '0; m_eie = '0; m_irq = '0; m_err = '0; m_st = '0; m_dc = '0;
            m_ctrl = '0; m_es_vld = 0; m_es_ch = '0; m_es_cause = '0;
            return;
        end
        ok    = (bus_wdata[7:6] == 2'b00);
        bit_n = 64'd1 << bus_wdata[5:0];
        clr_i = '0; clr_e = '0;
        m_st = '0; m_dc = '0;
        if (bus_wr) begin
            case (bus_addr)
                4'd0:  m_ctrl = bus_wdata & 32'h8000_000C;
                4'd2:  m_req[63:32] = bus_wdata;
                4'd3:  m_req[31:0]  = bus_wdata;
                4'd4:  m_eie[63:32] = bus_wdata;
                4'd5:  m_eie[31:0]  = bus_wdata;
                4'd6:  if (ok) m_req = m_req | bit_n;
                4'd7:  if (ok) m_req = m_req & ~bit_n;
                4'd8:  if (ok) m_eie = m_eie | bit_n;
                4'd9:  if (ok) m_eie = m_eie & ~bit_n;
                4'd10: if (ok) m_st = bit_n;
                4'd11: if (ok) m_dc = bit_n;
                4'd12: clr_i[63:32] = bus_wdata;
                4'd13: clr_i[31:0]  = bus_wdata;
                4'd14: clr_e[63:32] = bus_wdata;
                4'd15: clr_e[31:0]  = bus_wdata;
                default: ;
            endcase
        end
        eev   = ev_err_vld ? (64'd1 << ev_err_ch) : 64'd0;
        m_irq = (m_irq & ~clr_i) | ev_done;
        m_err = (m_err & ~clr_e) | eev;
        rel = m_es_vld && clr_e[m_es_ch] && !(ev_err_vld && ev_err_ch == m_es_ch);
        if (ev_err_vld && (!m_es_vld || rel)) begin
            m_es_vld = 1; m_es_ch = ev_err_ch; m_es_cause = ev_err_cause & 16'hC0FF;
        end else if (rel) begin
            m_es_vld = 0; m_es_ch = '0; m_es_cause = '0;
        end
    endtask

    task automatic compare_outputs();
        logic m_irq_out;
        m_irq_out = (|m_irq) | (|(m_err & m_eie));
        chk(req_en == m_req, "R3 req_en", req_en, m_req);
        chk(err_ie == m_eie, "R4 err_ie", err_ie, m_eie);
        chk(start_pulse == m_st, "R5 start_pulse", start_pulse, m_st);
        chk(done_clr_pulse == m_dc, "R5 done_clr_pulse", done_clr_pulse, m_dc);
        chk(irq == m_irq_out, "R12 irq", 64'(irq), 64'(m_irq_out));
        chk({dyn_clk_en, rr_group, rr_chan} == {m_ctrl[31], m_ctrl[3], m_ctrl[2]}, "R11 mode bits",
            64'({dyn_clk_en, rr_group, rr_chan}), 64'({m_ctrl[31], m_ctrl[3], m_ctrl[2]}));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (model_live) compare_outputs();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        logic [31:0] e;
        bus_addr = a;
        #1;
        e = m_read(a);
        chk(bus_rdata == e, tag, 64'(bus_rdata), 64'(e));
    endtask

    task automatic err_ev(input logic [5:0] ch, input logic [15:0] cause);
        ev_err_vld = 1'b1; ev_err_ch = ch; ev_err_cause = cause;
    endtask

    task automatic ev_off();
        ev_err_vld = 1'b0; ev_err_ch = '0; ev_err_cause = '0; ev_done = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        model_live = 1;
        cyc();
        // R1: reset state
        for (int a = 0; a < 16; a++) rd(4'(a), "R1 reset read");

        // R11: control word masking
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, "R11 ctrl readback");
        wr(4'd0, 32'h0000_0004);
        rd(4'd0, "R11 ctrl partial");

        // R3 / R2: request enable commands and word mapping
        wr(4'd6, 32'd5);
        wr(4'd6, 32'd40);
        rd(4'd3, "R2 req lo word");
        rd(4'd2, "R2 req hi word");
        wr(4'd7, 32'd5);
        rd(4'd3, "R3 req cleared");
        wr(4'd2, 32'hA5A5_0000);
        rd(4'd2, "R2 req hi whole write");
        wr(4'd3, 32'h0000_00FF);
        rd(4'd3, "R2 req lo whole write");

        // R4: error-interrupt enable commands
        wr(4'd8, 32'd63);
        wr(4'd8, 32'd0);
        rd(4'd4, "R4 eie hi");
        wr(4'd9, 32'd63);
        rd(4'd4, "R4 eie hi cleared");
        rd(4'd5, "R4 eie lo");

        // R5: strobes
        wr(4'd10, 32'd33);
        cyc();
        wr(4'd11, 32'd2);
        cyc();

        // R6: malformed commands ignored, command ports read zero
        wr(4'd6, 32'h0000_0045);
        wr(4'd7, 32'h0000_0083);
        wr(4'd10, 32'h0000_00C1);
        rd(4'd3, "R6 req lo unchanged");
        rd(4'd2, "R6 req hi unchanged");
        for (int a = 6; a < 12; a++) rd(4'(a), "R6 cmd port reads zero");

        // R7: completion events and write-one-to-clear
        ev_done = (64'd1 << 3) | (64'd1 << 50);
        cyc();
        ev_off();
        rd(4'd13, "R7 irq lo set");
        rd(4'd12, "R7 irq hi set");
        wr(4'd13, 32'h0000_0000);
        rd(4'd13, "R7 zero write keeps");
        wr(4'd13, 32'hFFFF_FFFF);
        rd(4'd13, "R7 lo cleared");
        rd(4'd12, "R7 hi untouched");

        // R8: event beats a same-cycle clear
        ev_done = 64'd1 << 50;
        bus_wr = 1'b1; bus_addr = 4'd12; bus_wdata = 32'hFFFF_FFFF;
        cyc();
        bus_wr = 1'b0; ev_off();
        rd(4'd12, "R8 event wins");
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, "R7 hi cleared");

        // R9: first error captured and held
        err_ev(6'd10, 16'h4081);
        cyc();
        ev_off();
        rd(4'd1, "R9 first capture");
        err_ev(6'd20, 16'hFFFF);
        cyc();
        ev_off();
        rd(4'd1, "R9 held no overwrite");
        rd(4'd15, "R7 err pend lo");
        wr(4'd8, 32'd20);  // R12: enable error irq on 20

        // R10: clearing non-held channel keeps the record
        wr(4'd15, 32'h0010_0000);
        rd(4'd1, "R10 other clear keeps");
        wr(4'd9, 32'd20);  // R12: irq only from enabled errors now
        wr(4'd9, 32'd0);
        // R10: release with a simultaneous new error on channel 12 recaptures
        err_ev(6'd12, 16'hFFFF);
        bus_wr = 1'b1; bus_addr = 4'd15; bus_wdata = 32'h0000_0400;
        cyc();
        bus_wr = 1'b0; ev_off();
        rd(4'd1, "R10 recapture masked cause");
        // R10: clear with an error on the same held channel keeps it
        err_ev(6'd12, 16'h0002);
        bus_wr = 1'b1; bus_addr = 4'd15; bus_wdata = 32'h0000_1000;
        cyc();
        bus_wr = 1'b0; ev_off();
        rd(4'd1, "R10 same channel keeps");
        rd(4'd15, "R8 err pend kept");
        // R10: plain release
        wr(4'd15, 32'h0000_1000);
        rd(4'd1, "R10 released to zero");
        // R9: capture in the upper half after release
        err_ev(6'd61, 16'h8010);
        cyc();
        ev_off();
        rd(4'd1, "R9 upper channel capture");
        rd(4'd14, "R2 err pend hi word");
        wr(4'd14, 32'h2000_0000);
        rd(4'd1, "R10 released from hi word");
        cyc();
        summary();
    end
endmodule